// File: doc/BRIEF.md
# Interval Timer Control and Readback Port

This block is the byte-wide host side of a three-channel interval timer. A 2-bit address with separate read and write strobes reaches four locations. Addresses 0 to 2 are the data ports of channels 0 to 2, and address 3 takes control words. The counter cores sit outside the block. The block drives their mode and BCD fields, and it sends each one a single-cycle load strobe with a 16-bit initial count. In the other direction, it samples each core's live count and OUT level.

Each channel has its own port state. The write sequencer has the states `SEQ_FIRST` and `SEQ_SECOND`. The read sequencer uses the same two states. The count-latch machine has four states:
- `LAT_EMPTY`
- `LAT_LO_FINAL`, where the low byte is returned next and the latch is then released
- `LAT_HI_FINAL`, where the high byte is returned next and the latch is then released
- `LAT_PAIR_LO`, where the low byte is returned next and the machine moves to `LAT_HI_FINAL`

A one-bit status holder sits beside these machines.

The transitions are as follows:
- A word-mode byte write or live read toggles its sequencer between `SEQ_FIRST` and `SEQ_SECOND`.
- A control word carrying a new access mode returns both sequencers to `SEQ_FIRST`.
- A count latch moves the latch machine from `LAT_EMPTY` to one of the three loaded states, chosen by the access mode.
- Each data-port read moves a loaded latch machine one step toward `LAT_EMPTY`.

Top module: `tmr_regif`

## Requirements
- R1: A control word at address 3 is decoded as follows. Bits 7:6 give the channel and bits 5:4 give the access mode: 1 is low byte only, 2 is high byte only, 3 is low then high. Bits 3:1 give the operating mode and bit 0 gives BCD. When the access mode is non-zero, the channel's `ch_mode` and `ch_bcd` outputs take the new values in the cycle after the write. Mode values 6 and 7 are stored as 2 and 3. A control word never raises a load strobe, and mode and BCD change only on control words.
- R2: After reset, every channel is in access mode 3 with operating mode 0 and BCD 0. Both sequencers are at the first byte, and no count or status is latched. `bus_rdata` is 0 and no load strobe is active.
- R3: In low-only access, a data write loads `{8'h00, byte}`. In high-only access, it loads `{byte, 8'h00}`. The load appears as a one-cycle pulse on `ld_strobe[channel]` with `ld_value`, in the cycle after the write. At most one strobe bit is ever high.
- R4: In low-then-high access, the first data byte is held and no load occurs. The second byte loads `{second, first}`.
- R5: A control word with a non-zero access mode returns both byte sequencers of that channel to the first byte. This applies even in the middle of a word.
- R6: Live reads follow the access mode. Low-only access returns `cnt[7:0]` on every read. High-only access returns `cnt[15:8]` on every read. Low-then-high access alternates, starting with the low byte.
- R7: A counter-latch command (access field 0) captures the channel's count in the cycle of the command. Reads then return the captured value according to the access mode at latch time: the low byte only, the high byte only, or the low byte then the high byte. After that the latch is released and reads return live values again.
- R8: A count-latch request to a channel that holds an unread latched count is ignored. A status-latch request to a channel that holds an unread status is also ignored.
- R9: A control word with channel field 3 is a read-back command. Bits 1, 2 and 3 select channels 0, 1 and 2. When bit 5 is 0, the count of each selected channel is latched. When bit 4 is 0, the status of each selected channel is latched.
- R10: The latched status byte is `{OUT, 1'b0, access[1:0], mode[2:0], bcd}`, sampled in the cycle of the read-back command.
- R11: A data-port read returns the latched status if one is held, and consumes it. Otherwise it returns the next latched count byte if one is held. Otherwise it returns the live count.
- R12: Read data is registered, so `bus_rdata` shows the byte in the cycle after a read strobe and holds its value at all other times. A read of address 3 returns 0. If write and read strobes occur together, the read is dropped and the write is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Location: 0 to 2 are channel data ports, 3 is the control location |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe, one cycle per byte |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Registered read byte |
| ld_strobe | output | NCH | One-cycle count-load pulse, one bit per channel |
| ld_value | output | 16 | Initial count carried with the load pulse |
| ch_mode | output | 3*NCH | Operating mode per channel, channel c at bits 3c+2:3c |
| ch_bcd | output | NCH | BCD select per channel |
| cnt_live | input | 16*NCH | Live count of each core, channel c at bits 16c+15:16c |
| out_live | input | NCH | OUT level of each core |

## Verification
The bench changes the live count between a latch command and the reads that follow it. A design that sampled late, or that let a second latch command overwrite the first, would return the newer value. The bench also rewrites a control word between the two bytes of a word transfer. A sequencer that was not reset would then load a word assembled from the wrong bytes, or return the high byte first. A read-back that latches both status and count is followed by reads across two channels. These reads expose priority errors, such as a count byte returned before the status, or a status that is not consumed. A status-only read-back must leave the next read live. Mode folding, strobe placement and a write that collides with a read are each checked at the exact cycle they appear.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int MODE_W = 3;
    localparam int AW     = 2;
    localparam logic [AW-1:0] CTL_ADDR = 2'd3;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    typedef enum logic [1:0] {
        ACC_LATCH = 2'd0,
        ACC_LO    = 2'd1,
        ACC_HI    = 2'd2,
        ACC_WORD  = 2'd3
    } acc_e;

    typedef enum logic {
        SEQ_FIRST  = 1'b0,
        SEQ_SECOND = 1'b1
    } seq_e;

    typedef enum logic [1:0] {
        LAT_EMPTY    = 2'd0,
        LAT_LO_FINAL = 2'd1,
        LAT_HI_FINAL = 2'd2,
        LAT_PAIR_LO  = 2'd3
    } lat_e;

    function automatic logic [MODE_W-1:0] fold_mode(input logic [MODE_W-1:0] m);
        return (m[2] && m[1]) ? {1'b0, m[1:0]} : m;
    endfunction

    function automatic byte_t make_status(input logic out, input acc_e acc,
                                          input logic [MODE_W-1:0] mode, input logic bcd);
        return {out, 1'b0, acc, mode, bcd};
    endfunction
endpackage

// File: rtl/tmr_cmd_decode.sv
module tmr_cmd_decode
    import tmr_pkg::*;
#(
    parameter int NCH = 3
) (
    input  logic              wr,
    input  logic              rd,
    input  logic [AW-1:0]     addr,
    input  byte_t             wdata,
    output logic [NCH-1:0]    cw_load,
    output logic [NCH-1:0]    lat_cnt,
    output logic [NCH-1:0]    lat_sts,
    output logic [NCH-1:0]    data_wr,
    output logic [NCH-1:0]    data_rd,
    output acc_e              cw_acc,
    output logic [MODE_W-1:0] cw_mode,
    output logic              cw_bcd
);
    logic       is_ctl;
    logic       is_rb;
    logic [1:0] sel;
    logic       rd_go;

    assign is_ctl  = wr && (addr == CTL_ADDR);
    assign sel     = wdata[7:6];
    assign is_rb   = (sel == 2'd3);
    assign cw_acc  = acc_e'(wdata[5:4]);
    assign cw_mode = wdata[3:1];
    assign cw_bcd  = wdata[0];
    assign rd_go   = rd && !wr;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic hit;
        logic rb_pick;
        assign hit        = is_ctl && !is_rb && (sel == 2'(c));
        assign rb_pick    = is_ctl && is_rb && wdata[c+1];
        assign cw_load[c] = hit && (cw_acc != ACC_LATCH);
        assign lat_cnt[c] = (hit && (cw_acc == ACC_LATCH)) || (rb_pick && !wdata[5]);
        assign lat_sts[c] = rb_pick && !wdata[4];
        assign data_wr[c] = wr && (addr == AW'(c));
        assign data_rd[c] = rd_go && (addr == AW'(c));
    end
endmodule

// File: rtl/tmr_chan_port.sv
module tmr_chan_port
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cw_load,
    input  acc_e              cw_acc,
    input  logic [MODE_W-1:0] cw_mode,
    input  logic              cw_bcd,
    input  logic              lat_cnt,
    input  logic              lat_sts,
    input  logic              data_wr,
    input  logic              data_rd,
    input  byte_t             wbyte,
    input  cnt_t              cnt_live,
    input  logic              out_live,
    output byte_t             rbyte,
    output logic              ld_req,
    output cnt_t              ld_word,
    output logic [MODE_W-1:0] mode_o,
    output logic              bcd_o
);
    acc_e              acc_q,  acc_n;
    logic [MODE_W-1:0] mode_q, mode_n;
    logic              bcd_q,  bcd_n;
    seq_e              wseq_q, wseq_n;
    seq_e              rseq_q, rseq_n;
    lat_e              lat_q,  lat_n;
    cnt_t              lval_q, lval_n;
    byte_t             sts_q,  sts_n;
    logic              sfull_q, sfull_n;
    byte_t             wlo_q,  wlo_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q   <= ACC_WORD;
            mode_q  <= '0;
            bcd_q   <= 1'b0;
            wseq_q  <= SEQ_FIRST;
            rseq_q  <= SEQ_FIRST;
            lat_q   <= LAT_EMPTY;
            lval_q  <= '0;
            sts_q   <= '0;
            sfull_q <= 1'b0;
            wlo_q   <= '0;
        end else begin
            acc_q   <= acc_n;
            mode_q  <= mode_n;
            bcd_q   <= bcd_n;
            wseq_q  <= wseq_n;
            rseq_q  <= rseq_n;
            lat_q   <= lat_n;
            lval_q  <= lval_n;
            sts_q   <= sts_n;
            sfull_q <= sfull_n;
            wlo_q   <= wlo_n;
        end
    end

    always_comb begin
        acc_n   = acc_q;
        mode_n  = mode_q;
        bcd_n   = bcd_q;
        wseq_n  = wseq_q;
        rseq_n  = rseq_q;
        lat_n   = lat_q;
        lval_n  = lval_q;
        sts_n   = sts_q;
        sfull_n = sfull_q;
        wlo_n   = wlo_q;

        if (cw_load) begin
            acc_n  = cw_acc;
            mode_n = fold_mode(cw_mode);
            bcd_n  = cw_bcd;
            wseq_n = SEQ_FIRST;
            rseq_n = SEQ_FIRST;
        end

        if (lat_cnt && (lat_q == LAT_EMPTY)) begin
            lval_n = cnt_live;
            unique case (acc_q)
                ACC_HI:   lat_n = LAT_HI_FINAL;
                ACC_WORD: lat_n = LAT_PAIR_LO;
                default:  lat_n = LAT_LO_FINAL;
            endcase
        end

        if (lat_sts && !sfull_q) begin
            sts_n   = make_status(out_live, acc_q, mode_q, bcd_q);
            sfull_n = 1'b1;
        end

        if (data_wr && (acc_q == ACC_WORD)) begin
            unique case (wseq_q)
                SEQ_FIRST: begin
                    wlo_n  = wbyte;
                    wseq_n = SEQ_SECOND;
                end
                SEQ_SECOND: wseq_n = SEQ_FIRST;
            endcase
        end

        if (data_rd) begin
            if (sfull_q) begin
                sfull_n = 1'b0;
            end else if (lat_q != LAT_EMPTY) begin
                unique case (lat_q)
                    LAT_PAIR_LO: lat_n = LAT_HI_FINAL;
                    default:     lat_n = LAT_EMPTY;
                endcase
            end else if (acc_q == ACC_WORD) begin
                unique case (rseq_q)
                    SEQ_FIRST:  rseq_n = SEQ_SECOND;
                    SEQ_SECOND: rseq_n = SEQ_FIRST;
                endcase
            end
        end
    end

    always_comb begin
        rbyte = cnt_live[BYTE_W-1:0];
        if (sfull_q) begin
            rbyte = sts_q;
        end else begin
            unique case (lat_q)
                LAT_LO_FINAL, LAT_PAIR_LO: rbyte = lval_q[BYTE_W-1:0];
                LAT_HI_FINAL:              rbyte = lval_q[CNT_W-1:BYTE_W];
                LAT_EMPTY: begin
                    unique case (acc_q)
                        ACC_HI:   rbyte = cnt_live[CNT_W-1:BYTE_W];
                        ACC_WORD: rbyte = (rseq_q == SEQ_SECOND) ? cnt_live[CNT_W-1:BYTE_W]
                                                                 : cnt_live[BYTE_W-1:0];
                        default:  rbyte = cnt_live[BYTE_W-1:0];
                    endcase
                end
            endcase
        end

        ld_req = data_wr && ((acc_q != ACC_WORD) || (wseq_q == SEQ_SECOND));
        unique case (acc_q)
            ACC_HI:   ld_word = {wbyte, {BYTE_W{1'b0}}};
            ACC_WORD: ld_word = {wbyte, wlo_q};
            default:  ld_word = {{BYTE_W{1'b0}}, wbyte};
        endcase

        mode_o = mode_q;
        bcd_o  = bcd_q;
    end
endmodule

// File: rtl/tmr_port_mux.sv
module tmr_port_mux
    import tmr_pkg::*;
#(
    parameter int NCH = 3
) (
    input  logic [AW-1:0]        addr,
    input  logic [NCH*BYTE_W-1:0] rbytes,
    input  logic [NCH-1:0]       ld_req,
    input  logic [NCH*CNT_W-1:0] ld_words,
    output byte_t                rsel,
    output cnt_t                 lsel
);
    always_comb begin
        rsel = '0;
        lsel = '0;
        for (int c = 0; c < NCH; c++) begin
            if (addr == AW'(c)) begin
                rsel = rbytes[c*BYTE_W +: BYTE_W];
            end
            if (ld_req[c]) begin
                lsel = lsel | ld_words[c*CNT_W +: CNT_W];
            end
        end
    end
endmodule

// File: rtl/tmr_regif.sv
module tmr_regif
    import tmr_pkg::*;
#(
    parameter int NCH = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [AW-1:0]           bus_addr,
    input  logic                    bus_wr,
    input  logic                    bus_rd,
    input  logic [BYTE_W-1:0]       bus_wdata,
    output logic [BYTE_W-1:0]       bus_rdata,
    output logic [NCH-1:0]          ld_strobe,
    output logic [CNT_W-1:0]        ld_value,
    output logic [NCH*MODE_W-1:0]   ch_mode,
    output logic [NCH-1:0]          ch_bcd,
    input  logic [NCH*CNT_W-1:0]    cnt_live,
    input  logic [NCH-1:0]          out_live
);
    logic [NCH-1:0]          cw_load, lat_cnt, lat_sts, data_wr, data_rd, ld_req;
    acc_e                    cw_acc;
    logic [MODE_W-1:0]       cw_mode;
    logic                    cw_bcd;
    logic [NCH*BYTE_W-1:0]   rbytes;
    logic [NCH*CNT_W-1:0]    ld_words;
    byte_t                   rsel;
    cnt_t                    lsel;
    logic                    rd_go;
    byte_t                   rdata_q;
    logic [NCH-1:0]          strobe_q;
    cnt_t                    lvalue_q;

    assign rd_go = bus_rd && !bus_wr;

    tmr_cmd_decode #(.NCH(NCH)) u_dec (
        .wr      (bus_wr),
        .rd      (bus_rd),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .cw_load (cw_load),
        .lat_cnt (lat_cnt),
        .lat_sts (lat_sts),
        .data_wr (data_wr),
        .data_rd (data_rd),
        .cw_acc  (cw_acc),
        .cw_mode (cw_mode),
        .cw_bcd  (cw_bcd)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_port
        tmr_chan_port u_port (
            .clk      (clk),
            .rst_n    (rst_n),
            .cw_load  (cw_load[c]),
            .cw_acc   (cw_acc),
            .cw_mode  (cw_mode),
            .cw_bcd   (cw_bcd),
            .lat_cnt  (lat_cnt[c]),
            .lat_sts  (lat_sts[c]),
            .data_wr  (data_wr[c]),
            .data_rd  (data_rd[c]),
            .wbyte    (bus_wdata),
            .cnt_live (cnt_live[c*CNT_W +: CNT_W]),
            .out_live (out_live[c]),
            .rbyte    (rbytes[c*BYTE_W +: BYTE_W]),
            .ld_req   (ld_req[c]),
            .ld_word  (ld_words[c*CNT_W +: CNT_W]),
            .mode_o   (ch_mode[c*MODE_W +: MODE_W]),
            .bcd_o    (ch_bcd[c])
        );
    end

    tmr_port_mux #(.NCH(NCH)) u_mux (
        .addr     (bus_addr),
        .rbytes   (rbytes),
        .ld_req   (ld_req),
        .ld_words (ld_words),
        .rsel     (rsel),
        .lsel     (lsel)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q  <= '0;
            strobe_q <= '0;
            lvalue_q <= '0;
        end else begin
            if (rd_go) begin
                rdata_q <= rsel;
            end
            strobe_q <= ld_req;
            if (|ld_req) begin
                lvalue_q <= lsel;
            end
        end
    end

    assign bus_rdata = rdata_q;
    assign ld_strobe = strobe_q;
    assign ld_value  = lvalue_q;
endmodule

// File: rtl/tmr_regif_chk.sv
module tmr_regif_chk
    import tmr_pkg::*;
#(
    parameter int NCH = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [AW-1:0]         bus_addr,
    input logic                  bus_wr,
    input logic                  bus_rd,
    input logic [BYTE_W-1:0]     bus_rdata,
    input logic [NCH-1:0]        ld_strobe,
    input logic [NCH*MODE_W-1:0] ch_mode
);
    assert_one_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ld_strobe));

    assert_ctl_no_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == CTL_ADDR) |=> (ld_strobe == '0));

    assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && !bus_wr) |=> $stable(bus_rdata));

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        assert_load_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
            ld_strobe[c] |-> ($past(bus_wr) && $past(bus_addr) == AW'(c)));

        assert_mode_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
            ch_mode[c*MODE_W +: MODE_W] <= 3'd5);

        assert_mode_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
            !(bus_wr && bus_addr == CTL_ADDR) |=> $stable(ch_mode[c*MODE_W +: MODE_W]));
    end
endmodule

bind tmr_regif tmr_regif_chk #(.NCH(NCH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .ld_strobe (ld_strobe),
    .ch_mode   (ch_mode)
);

// File: tb/tmr_regif_tb.sv
module tmr_regif_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [2:0]  ld_strobe;
    logic [15:0] ld_value;
    logic [8:0]  ch_mode;
    logic [2:0]  ch_bcd;
    logic [15:0] cnt0 = '0, cnt1 = '0, cnt2 = '0;
    logic [47:0] cnt_live;
    logic [2:0]  out_live = '0;
    int          n_chk = 0;
    int          n_fail = 0;
    logic [7:0]  v;

    assign cnt_live = {cnt2, cnt1, cnt0};

    always #5 clk = ~clk;

    tmr_regif u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ld_strobe(ld_strobe),
        .ld_value(ld_value), .ch_mode(ch_mode), .ch_bcd(ch_bcd),
        .cnt_live(cnt_live), .out_live(out_live)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic t_reset;
        chk("R2 mode", {7'd0, ch_mode}, 16'h0000);
        chk("R2 bcd", {13'd0, ch_bcd}, 16'h0000);
        chk("R2 strobe", {13'd0, ld_strobe}, 16'h0000);
        chk("R2 rdata", {8'd0, bus_rdata}, 16'h0000);
        cnt0 = 16'hBEEF;
        rd(2'd0, v); chk("R2 word default low", {8'd0, v}, 16'h00EF);
        rd(2'd0, v); chk("R2 word default high", {8'd0, v}, 16'h00BE);
    endtask

    task automatic t_ctl_decode;
        wr(2'd3, 8'h57);
        chk("R1 ch1 mode", {13'd0, ch_mode[5:3]}, 16'd3);
        chk("R1 ch1 bcd", {15'd0, ch_bcd[1]}, 16'd1);
        chk("R1 ctl no strobe", {13'd0, ld_strobe}, 16'd0);
        wr(2'd3, 8'hBE);
        chk("R1 mode7 folds", {13'd0, ch_mode[8:6]}, 16'd3);
        wr(2'd3, 8'hBC);
        chk("R1 mode6 folds", {13'd0, ch_mode[8:6]}, 16'd2);
    endtask

    task automatic t_write_single;
        wr(2'd1, 8'hA5);
        chk("R3 lsb strobe", {13'd0, ld_strobe}, 16'h0002);
        chk("R3 lsb value", ld_value, 16'h00A5);
        @(negedge clk);
        chk("R3 strobe one cycle", {13'd0, ld_strobe}, 16'h0000);
        wr(2'd3, 8'h64);
        wr(2'd1, 8'h3C);
        chk("R3 msb strobe", {13'd0, ld_strobe}, 16'h0002);
        chk("R3 msb value", ld_value, 16'h3C00);
    endtask

    task automatic t_write_word;
        wr(2'd3, 8'h34);
        wr(2'd0, 8'h78);
        chk("R4 first byte held", {13'd0, ld_strobe}, 16'h0000);
        wr(2'd0, 8'h12);
        chk("R4 word strobe", {13'd0, ld_strobe}, 16'h0001);
        chk("R4 word value", ld_value, 16'h1278);
    endtask

    task automatic t_seq_restart;
        wr(2'd0, 8'h11);
        wr(2'd3, 8'h34);
        wr(2'd0, 8'h22);
        chk("R5 write seq restarted", {13'd0, ld_strobe}, 16'h0000);
        wr(2'd0, 8'h33);
        chk("R5 word after restart", ld_value, 16'h3322);
        cnt0 = 16'hBEEF;
        rd(2'd0, v); chk("R5 read first", {8'd0, v}, 16'h00EF);
        wr(2'd3, 8'h34);
        rd(2'd0, v); chk("R5 read seq restarted", {8'd0, v}, 16'h00EF);
        rd(2'd0, v); chk("R5 read second", {8'd0, v}, 16'h00BE);
    endtask

    task automatic t_live;
        cnt1 = 16'h1234;
        wr(2'd3, 8'h50);
        rd(2'd1, v); chk("R6 lsb live a", {8'd0, v}, 16'h0034);
        rd(2'd1, v); chk("R6 lsb live b", {8'd0, v}, 16'h0034);
        wr(2'd3, 8'h60);
        rd(2'd1, v); chk("R6 msb live a", {8'd0, v}, 16'h0012);
        rd(2'd1, v); chk("R6 msb live b", {8'd0, v}, 16'h0012);
        wr(2'd3, 8'h70);
        rd(2'd1, v); chk("R6 word live 1", {8'd0, v}, 16'h0034);
        rd(2'd1, v); chk("R6 word live 2", {8'd0, v}, 16'h0012);
        rd(2'd1, v); chk("R6 word live 3", {8'd0, v}, 16'h0034);
    endtask

    task automatic t_latch;
        wr(2'd3, 8'hB4);
        cnt2 = 16'hABCD;
        wr(2'd3, 8'h80);
        chk("R7 latch keeps mode", {13'd0, ch_mode[8:6]}, 16'd2);
        cnt2 = 16'h5555;
        wr(2'd3, 8'h80);
        rd(2'd2, v); chk("R8 latched low kept", {8'd0, v}, 16'h00CD);
        rd(2'd2, v); chk("R7 latched high", {8'd0, v}, 16'h00AB);
        rd(2'd2, v); chk("R7 released live low", {8'd0, v}, 16'h0055);
        rd(2'd2, v); chk("R7 released live high", {8'd0, v}, 16'h0055);
        wr(2'd3, 8'h90);
        cnt2 = 16'h4321;
        wr(2'd3, 8'h80);
        cnt2 = 16'h0000;
        rd(2'd2, v); chk("R7 lsb latch", {8'd0, v}, 16'h0021);
        rd(2'd2, v); chk("R7 lsb latch released", {8'd0, v}, 16'h0000);
    endtask

    task automatic t_readback;
        wr(2'd3, 8'h34);
        wr(2'd3, 8'h67);
        out_live = 3'b010;
        cnt0 = 16'h0102;
        cnt1 = 16'h0A0B;
        wr(2'd3, 8'hC6);
        cnt0 = 16'hFFFF; cnt1 = 16'hFFFF; out_live = 3'b000;
        rd(2'd0, v); chk("R10 ch0 status", {8'd0, v}, 16'h0034);
        rd(2'd0, v); chk("R11 ch0 latched low", {8'd0, v}, 16'h0002);
        rd(2'd0, v); chk("R9 ch0 latched high", {8'd0, v}, 16'h0001);
        rd(2'd0, v); chk("R11 ch0 live", {8'd0, v}, 16'h00FF);
        rd(2'd1, v); chk("R10 ch1 status", {8'd0, v}, 16'h00A7);
        rd(2'd1, v); chk("R9 ch1 latched msb", {8'd0, v}, 16'h000A);
        rd(2'd1, v); chk("R11 ch1 live", {8'd0, v}, 16'h00FF);
        out_live = 3'b100;
        wr(2'd3, 8'hE8);
        out_live = 3'b000;
        wr(2'd3, 8'hE8);
        cnt2 = 16'h7788;
        rd(2'd2, v); chk("R8 first status kept", {8'd0, v}, 16'h0090);
        rd(2'd2, v); chk("R9 status only no count", {8'd0, v}, 16'h0088);
    endtask

    task automatic t_misc;
        rd(2'd3, v); chk("R12 ctl read zero", {8'd0, v}, 16'h0000);
        wr(2'd3, 8'h10);
        cnt0 = 16'h4455;
        rd(2'd0, v); chk("R12 read lsb", {8'd0, v}, 16'h0055);
        repeat (3) @(negedge clk);
        chk("R12 rdata holds", {8'd0, bus_rdata}, 16'h0055);
        @(negedge clk);
        bus_addr = 2'd0; bus_wdata = 8'h9A; bus_wr = 1'b1; bus_rd = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        chk("R12 collide write done", {13'd0, ld_strobe}, 16'h0001);
        chk("R12 collide value", ld_value, 16'h009A);
        chk("R12 collide read dropped", {8'd0, bus_rdata}, 16'h0055);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ctl_decode();
        t_write_single();
        t_write_word();
        t_seq_restart();
        t_live();
        t_latch();
        t_readback();
        t_misc();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule